// File: doc/BRIEF.md
# DDR Command Spacing Timer

This block sits beside the command scheduler of a DDR SDRAM controller. It keeps two minimum spacings between the commands the scheduler issues. The first is the gap from a read to a later write. The second is the gap from a refresh to a later activate. The timing values arrive as static configuration pins. The block watches every command the scheduler issues and drives one "allowed" flag for each command class it constrains. The scheduler must hold back a write while `wr_ok` is low, and an activate while `act_ok` is low.

The read-to-write spacing comes from the CAS latency, the write latency and the burst length, with a programmable extra added on top. The refresh recovery spacing is a seven-bit value built from two configuration fields, plus a fixed offset. Each spacing runs on its own down-counter. An issued command is reported as a one-cycle pulse on `cmd_valid`. The command port has no ready signal and applies no back-pressure: the scheduler reads the allowed flags before it issues, and the block records whatever is presented.

Top module: `ddr_cmd_spacing`

## Requirements
- R1: CAS latency is given in half-clock units on `cfg_cas_half`. A fractional latency is rounded up to the next whole clock before any other use.
- R2: The baseline read-to-write gap is ceil(CL) − WL + BL/2 + 2 clocks. BL/2 is 4 when `cfg_bl8` is 1 and 2 when it is 0.
- R3: The extra turnaround field `cfg_rtw_extra` (0..3) is added to the baseline gap. A value of 0 enforces the baseline alone.
- R4: If the baseline formula gives less than 1, the baseline is taken as 1. The extra turnaround is then added to this clamped baseline.
- R5: The gap is counted in clocks from the cycle in which a read is issued. If a read is issued in cycle t with gap G, `wr_ok` is low from cycle t+1 through cycle t+G−1 and high in cycle t+G. A read issued during this countdown restarts the gap from that read.
- R6: The refresh recovery is R = {`cfg_rfc_ext`,`cfg_rfc_base`} + 8 clocks, where the extended field forms the upper three bits of the seven-bit value. If a refresh is issued in cycle t, `act_ok` is low from cycle t+1 through t+R−1 and high in cycle t+R.
- R7: A refresh issued while recovery is still counting reloads the full recovery count from that refresh.
- R8: Only reads affect `wr_ok`, and only refreshes affect `act_ok`. Command kind encoding on `cmd_kind`: 0 = read, 1 = write, 2 = refresh, 3 = activate.
- R9: Synchronous active-high reset clears both counters. In the cycle after reset, `wr_ok` and `act_ok` are both high, even if a countdown was in progress.
- R10: A cycle with `cmd_valid` low has no effect on either counter, whatever value `cmd_kind` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | Kind of issued command (0 read, 1 write, 2 refresh, 3 activate) |
| cfg_cas_half | input | CL_W (5) | CAS latency in half-clock units |
| cfg_wr_lat | input | WL_W (4) | Write latency in clocks |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cfg_rtw_extra | input | XTRA_W (2) | Extra read-to-write clocks |
| cfg_rfc_ext | input | EXT_W (3) | Upper bits of refresh recovery |
| cfg_rfc_base | input | BASE_W (4) | Lower bits of refresh recovery |
| wr_ok | output | 1 | A write may be issued this cycle |
| act_ok | output | 1 | An activate may be issued this cycle |

## Verification
Both flags are registered one stage deep. A command sampled at the edge ending cycle t first affects its flag in cycle t+1, and the flag comes back high in exactly cycle t+gap. The bench drives each command for one cycle at a falling edge. It then reads the flag at every following falling edge, counting from 1 at the first of them. The count at which the flag first reads high is compared with the gap worked out from the configuration. Checks on unaffected flags, reset and idle cycles are taken at the first falling edge after the edge that captured the stimulus.

// File: rtl/ddr_spacing_pkg.sv
package ddr_spacing_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_REF = 2'd2,
    CMD_ACT = 2'd3
  } ddr_cmd_e;
endpackage

// File: rtl/rtw_gap_calc.sv
// Read-to-write gap (minus one) from latencies, burst length and extra clocks.
module rtw_gap_calc #(
  parameter int CL_W   = 5,
  parameter int WL_W   = 4,
  parameter int XTRA_W = 2,
  parameter int GAP_W  = 5
) (
  input  logic [CL_W-1:0]   cas_half,
  input  logic [WL_W-1:0]   wr_lat,
  input  logic              bl8,
  input  logic [XTRA_W-1:0] extra,
  output logic [GAP_W-1:0]  gap_m1
);
  int cl_whole;
  int burst_half;
  int baseline;
  int total;

  always_comb begin
    cl_whole   = (int'(cas_half) + 1) / 2;   // round half-clocks up
    burst_half = bl8 ? 4 : 2;
    baseline   = cl_whole - int'(wr_lat) + burst_half + 2;
    if (baseline < 1) baseline = 1;
    total      = baseline + int'(extra);
    gap_m1     = GAP_W'(total - 1);
  end
endmodule

// File: rtl/rfc_gap_calc.sv
// Refresh recovery (minus one): concatenated fields plus fixed offset.
module rfc_gap_calc #(
  parameter int EXT_W  = 3,
  parameter int BASE_W = 4,
  parameter int OFFSET = 8,
  parameter int GAP_W  = 8
) (
  input  logic [EXT_W-1:0]  ext_bits,
  input  logic [BASE_W-1:0] base_bits,
  output logic [GAP_W-1:0]  gap_m1
);
  localparam int JOIN_W = EXT_W + BASE_W;
  logic [JOIN_W-1:0] joined;

  always_comb begin
    joined = {ext_bits, base_bits};
    gap_m1 = GAP_W'(int'(joined) + OFFSET - 1);
  end
endmodule

// File: rtl/gap_timer.sv
// Loadable down-counter; idle when it has reached zero.
module gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] left,
  output logic         idle
);
  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (load)        left <= load_val;
    else if (left != '0)  left <= left - 1'b1;
  end

  assign idle = (left == '0);
endmodule

// File: rtl/ddr_cmd_spacing.sv
module ddr_cmd_spacing #(
  parameter int CL_W       = 5,
  parameter int WL_W       = 4,
  parameter int XTRA_W     = 2,
  parameter int EXT_W      = 3,
  parameter int BASE_W     = 4,
  parameter int RFC_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [CL_W-1:0]   cfg_cas_half,
  input  logic [WL_W-1:0]   cfg_wr_lat,
  input  logic              cfg_bl8,
  input  logic [XTRA_W-1:0] cfg_rtw_extra,
  input  logic [EXT_W-1:0]  cfg_rfc_ext,
  input  logic [BASE_W-1:0] cfg_rfc_base,
  output logic              wr_ok,
  output logic              act_ok
);
  import ddr_spacing_pkg::*;

  localparam int MAX_TURN = (2**CL_W) / 2 + 4 + 2 + (2**XTRA_W - 1);
  localparam int TURN_W   = $clog2(MAX_TURN);
  localparam int MAX_RFC  = 2**(EXT_W + BASE_W) - 1 + RFC_OFFSET;
  localparam int RFC_W    = $clog2(MAX_RFC);

  logic              rd_fire;
  logic              ref_fire;
  logic [TURN_W-1:0] rtw_load;
  logic [RFC_W-1:0]  rfc_load;
  logic [TURN_W-1:0] rtw_left;
  logic [RFC_W-1:0]  rfc_left;

  assign rd_fire  = cmd_valid && (cmd_kind == CMD_RD);
  assign ref_fire = cmd_valid && (cmd_kind == CMD_REF);

  rtw_gap_calc #(
    .CL_W(CL_W), .WL_W(WL_W), .XTRA_W(XTRA_W), .GAP_W(TURN_W)
  ) u_rtw_calc (
    .cas_half(cfg_cas_half),
    .wr_lat  (cfg_wr_lat),
    .bl8     (cfg_bl8),
    .extra   (cfg_rtw_extra),
    .gap_m1  (rtw_load)
  );

  rfc_gap_calc #(
    .EXT_W(EXT_W), .BASE_W(BASE_W), .OFFSET(RFC_OFFSET), .GAP_W(RFC_W)
  ) u_rfc_calc (
    .ext_bits (cfg_rfc_ext),
    .base_bits(cfg_rfc_base),
    .gap_m1   (rfc_load)
  );

  gap_timer #(.W(TURN_W)) u_rtw_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (rd_fire),
    .load_val(rtw_load),
    .left    (rtw_left),
    .idle    (wr_ok)
  );

  gap_timer #(.W(RFC_W)) u_rfc_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (ref_fire),
    .load_val(rfc_load),
    .left    (rfc_left),
    .idle    (act_ok)
  );
endmodule

// File: rtl/ddr_cmd_spacing_chk.sv
module ddr_cmd_spacing_chk #(
  parameter int TURN_W = 5,
  parameter int RFC_W  = 8,
  parameter int XTRA_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_kind,
  input logic [XTRA_W-1:0] cfg_rtw_extra,
  input logic              wr_ok,
  input logic              act_ok,
  input logic [TURN_W-1:0] rtw_left,
  input logic [RFC_W-1:0]  rfc_left
);
  logic rd_seen;
  logic ref_seen;
  assign rd_seen  = cmd_valid && (cmd_kind == 2'd0);
  assign ref_seen = cmd_valid && (cmd_kind == 2'd2);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (wr_ok && act_ok)); // R9

  AST_EXTRA_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rd_seen && cfg_rtw_extra != '0) |=> !wr_ok); // R3

  AST_RTW_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!wr_ok && !rd_seen) |=> (rtw_left == $past(rtw_left) - 1'b1)); // R5

  AST_REFRESH_BLOCKS_ACT: assert property (@(posedge clk) disable iff (rst)
    ref_seen |=> !act_ok); // R6

  AST_RFC_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!act_ok && !ref_seen) |=> (rfc_left == $past(rfc_left) - 1'b1)); // R7

  AST_WR_HELD_OPEN: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !rd_seen) |=> wr_ok); // R8

  AST_ACT_HELD_OPEN: assert property (@(posedge clk) disable iff (rst)
    (act_ok && !ref_seen) |=> act_ok); // R10
endmodule

bind ddr_cmd_spacing ddr_cmd_spacing_chk #(
  .TURN_W(TURN_W), .RFC_W(RFC_W), .XTRA_W(XTRA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_kind     (cmd_kind),
  .cfg_rtw_extra(cfg_rtw_extra),
  .wr_ok        (wr_ok),
  .act_ok       (act_ok),
  .rtw_left     (rtw_left),
  .rfc_left     (rfc_left)
);

// File: tb/ddr_cmd_spacing_tb.sv
module ddr_cmd_spacing_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4:0] cl;
    logic [3:0] wl;
    logic       bl8;
    logic [1:0] ex;
    logic [2:0] rext;
    logic [3:0] rbase;
    logic [7:0] exp_rtw;
    logic [7:0] exp_rfc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{5'd10, 4'd4, 1'b1, 2'd0, 3'd0, 4'd0,  8'd7,  8'd8},   // R2 5-4+4+2, R6 0+8
    '{5'd11, 4'd4, 1'b1, 2'd2, 3'd1, 4'd5,  8'd10, 8'd29},  // R1 5.5->6, R3 +2
    '{5'd6,  4'd3, 1'b0, 2'd3, 3'd7, 4'd15, 8'd7,  8'd135}, // R3 +3, R6 max
    '{5'd7,  4'd1, 1'b0, 2'd1, 3'd3, 4'd2,  8'd8,  8'd58},  // R1 3.5->4
    '{5'd2,  4'd8, 1'b0, 2'd0, 3'd0, 4'd1,  8'd1,  8'd9},   // R4 clamp
    '{5'd31, 4'd0, 1'b1, 2'd3, 3'd4, 4'd8,  8'd25, 8'd80}   // R1 15.5->16
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [4:0] cfg_cas_half = 5'd10;
  logic [3:0] cfg_wr_lat = 4'd4;
  logic       cfg_bl8 = 1'b1;
  logic [1:0] cfg_rtw_extra = 2'd0;
  logic [2:0] cfg_rfc_ext = 3'd0;
  logic [3:0] cfg_rfc_base = 4'd0;
  logic       wr_ok;
  logic       act_ok;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_spacing u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cfg_cas_half(cfg_cas_half), .cfg_wr_lat(cfg_wr_lat), .cfg_bl8(cfg_bl8),
    .cfg_rtw_extra(cfg_rtw_extra), .cfg_rfc_ext(cfg_rfc_ext),
    .cfg_rfc_base(cfg_rfc_base), .wr_ok(wr_ok), .act_ok(act_ok)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  // Drive one command for one cycle; returns at the next falling edge.
  task automatic issue(input logic [1:0] kind, input logic vld);
    cmd_valid = vld;
    cmd_kind  = kind;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_kind  = 2'd1;
  endtask

  task automatic measure(input bit on_act, output int n);
    n = 1;
    while (!(on_act ? act_ok : wr_ok) && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int g;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 wr_ok after reset", int'(wr_ok), 1);
    check("R9 act_ok after reset", int'(act_ok), 1);

    for (int i = 0; i < NVEC; i++) begin
      cfg_cas_half  = VECS[i].cl;
      cfg_wr_lat    = VECS[i].wl;
      cfg_bl8       = VECS[i].bl8;
      cfg_rtw_extra = VECS[i].ex;
      cfg_rfc_ext   = VECS[i].rext;
      cfg_rfc_base  = VECS[i].rbase;
      do_reset();
      issue(2'd0, 1'b1);
      measure(1'b0, g);
      check($sformatf("R2 R5 read-to-write gap vec%0d", i), g, int'(VECS[i].exp_rtw));
      issue(2'd2, 1'b1);
      measure(1'b1, g);
      check($sformatf("R6 refresh recovery vec%0d", i), g, int'(VECS[i].exp_rfc));
    end

    // Configuration of vector 0: gap 7, recovery 8
    cfg_cas_half = 5'd10; cfg_wr_lat = 4'd4; cfg_bl8 = 1'b1;
    cfg_rtw_extra = 2'd0; cfg_rfc_ext = 3'd0; cfg_rfc_base = 4'd0;
    do_reset();

    // R10 idle cycles with read/refresh kinds do nothing
    issue(2'd0, 1'b0);
    check("R10 wr_ok with valid low", int'(wr_ok), 1);
    issue(2'd2, 1'b0);
    check("R10 act_ok with valid low", int'(act_ok), 1);

    // R8 write and activate leave both flags open
    issue(2'd1, 1'b1);
    check("R8 wr_ok after write", int'(wr_ok), 1);
    issue(2'd3, 1'b1);
    check("R8 act_ok after activate", int'(act_ok), 1);
    issue(2'd0, 1'b1);
    check("R8 act_ok after read", int'(act_ok), 1);
    measure(1'b0, g);
    issue(2'd2, 1'b1);
    check("R8 wr_ok after refresh", int'(wr_ok), 1);
    measure(1'b1, g);

    // R5 second read restarts the turnaround
    issue(2'd0, 1'b1);
    @(negedge clk); @(negedge clk);
    issue(2'd0, 1'b1);
    measure(1'b0, g);
    check("R5 restarted gap", g, 7);

    // R7 second refresh reloads recovery
    issue(2'd2, 1'b1);
    @(negedge clk); @(negedge clk); @(negedge clk);
    issue(2'd2, 1'b1);
    measure(1'b1, g);
    check("R7 reloaded recovery", g, 8);

    // R9 reset in mid countdown
    issue(2'd0, 1'b1);
    issue(2'd2, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 wr_ok after mid reset", int'(wr_ok), 1);
    check("R9 act_ok after mid reset", int'(act_ok), 1);

    finish_run();
  end
endmodule